// File: doc/BRIEF.md
# Armed Control Register Bank

This block is a small bank of 8-bit control registers on a processor I/O port. The port presents a 3-bit address, write data and separate read and write enables. A register is touched only while the bus-grant input and the port-select strobe are also high. Three registers are plain read/write configuration registers.

A fourth register can be written but not read back. A read at its address returns an external 8-bit status value instead. The top bit of that write-only register is an arming bit for the fifth register. While the arming bit is low, the fifth register is held at zero and ignores writes. The moment the arming bit goes low, the register loses its contents.

All register contents are also driven out as outputs, so downstream logic can use them as mode bits.

Top module: `ctl_reg_bank`

## Requirements
- R1: A write to offset 0, 1 or 2 stores the write data on the next rising clock edge. The value then appears on that register's output and is returned by a read of the same offset.
- R2: While `rst` is high at a rising edge, every register clears to zero. Reset is synchronous and active-high.
- R3: A write takes effect only when `bus_grant`, `port_sel` and `wr_en` are all high. If any of them is low, no register changes.
- R4: `rdata` carries register data only when `bus_grant`, `port_sel` and `rd_en` are all high. Otherwise `rdata` is zero. Reads are combinational.
- R5: Offset 3 is write-only. A write there is visible on `arm_q`, and a read of offset 3 returns `ext_status`, never the stored value.
- R6: Bit 7 of the offset-3 register is the arming bit for offset 4. While it is low, `guard_q` and a read of offset 4 are zero, and writes to offset 4 are ignored.
- R7: After a single offset-3 write that sets bit 7, a write to offset 4 on the very next cycle is accepted. Offset 4 then reads back like an ordinary register.
- R8: When the arming bit falls, `guard_q` reads zero in that same cycle. The old value does not return if the arming bit is set again.
- R9: Offsets 5, 6 and 7 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Admits the external address/strobe path into the bank |
| port_sel | input | 1 | Port-select strobe from the address decoder |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| ext_status | input | 8 | External value returned by a read of offset 3 |
| rdata | output | 8 | Read data, zero when no read is active |
| ctl0_q | output | 8 | Offset 0 contents |
| ctl1_q | output | 8 | Offset 1 contents |
| ctl2_q | output | 8 | Offset 2 contents |
| arm_q | output | 8 | Offset 3 contents (bit 7 is the arming bit) |
| guard_q | output | 8 | Offset 4 contents as seen by the rest of the chip |

## Verification
On every cycle, the embedded assertions check several rules. Reset clears every register. No register moves without a qualified write. Committed writes land one edge later. Idle reads return zero, and offset 3 reads the external status. The guarded register stays cleared while the bank is disarmed.

Some behaviour only the bench's scenarios can show. These include that a write to the guarded register fails when not armed but succeeds one cycle after arming. They also include that dropping the arm wipes a stored value for good, and that offsets 5 to 7 are dead. The bench's per-cycle reference model covers these, along with the full read mux, under directed and random traffic.

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_grant,
  input  logic          port_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ext_status,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctl0_q,
  output logic [DW-1:0] ctl1_q,
  output logic [DW-1:0] ctl2_q,
  output logic [DW-1:0] arm_q,
  output logic [DW-1:0] guard_q
);
  localparam int ARM = DW - 1;
  localparam logic [AW-1:0] OFS_C0 = AW'(0);
  localparam logic [AW-1:0] OFS_C1 = AW'(1);
  localparam logic [AW-1:0] OFS_C2 = AW'(2);
  localparam logic [AW-1:0] OFS_ARM = AW'(3);
  localparam logic [AW-1:0] OFS_GRD = AW'(4);

  logic [DW-1:0] c0_r, c1_r, c2_r, arm_r, grd_r;
  logic wr_hit, rd_hit, armed;

  assign wr_hit = bus_grant & port_sel & wr_en;
  assign rd_hit = bus_grant & port_sel & rd_en;
  assign armed  = arm_r[ARM];

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_r  <= '0;
      c1_r  <= '0;
      c2_r  <= '0;
      arm_r <= '0;
      grd_r <= '0;
    end else begin
      if (wr_hit) begin
        case (addr)
          OFS_C0:  c0_r  <= wdata;
          OFS_C1:  c1_r  <= wdata;
          OFS_C2:  c2_r  <= wdata;
          OFS_ARM: arm_r <= wdata;
          default: ;
        endcase
      end
      if (!armed) grd_r <= '0;
      else if (wr_hit && addr == OFS_GRD) grd_r <= wdata;
    end
  end

  assign ctl0_q  = c0_r;
  assign ctl1_q  = c1_r;
  assign ctl2_q  = c2_r;
  assign arm_q   = arm_r;
  assign guard_q = armed ? grd_r : '0;

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (addr)
        OFS_C0:  rdata = c0_r;
        OFS_C1:  rdata = c1_r;
        OFS_C2:  rdata = c2_r;
        OFS_ARM: rdata = ext_status;
        OFS_GRD: rdata = guard_q;
        default: rdata = '0;
      endcase
    end
  end

  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> (ctl0_q == '0 && ctl1_q == '0 && ctl2_q == '0 && arm_q == '0 && guard_q == '0));

  assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_grant && port_sel && wr_en) |=>
      ($stable(ctl0_q) && $stable(ctl1_q) && $stable(ctl2_q) && $stable(arm_q) && $stable(guard_q)));

  assert_commit_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && port_sel && wr_en && addr == OFS_C1) |=> ctl1_q == $past(wdata));

  assert_idle_read_R4: assert property (@(posedge clk) disable iff (rst)
    !(bus_grant && port_sel && rd_en) |-> rdata == '0);

  assert_ext_read_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && port_sel && rd_en && addr == OFS_ARM) |-> rdata == ext_status);

  assert_disarmed_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !arm_q[ARM] |=> grd_r == '0);

  assert_armed_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && port_sel && wr_en && addr == OFS_GRD && arm_q[ARM]) |=> guard_q == $past(wdata));
endmodule

// File: tb/test_ctl_reg_bank.sv
`timescale 1ns/1ps
module test_ctl_reg_bank;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_grant = 0, port_sel = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, ext_status = '0;
  logic [7:0] rdata, ctl0_q, ctl1_q, ctl2_q, arm_q, guard_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctl_reg_bank i_ctl_reg_bank (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .port_sel(port_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .ext_status(ext_status), .rdata(rdata), .ctl0_q(ctl0_q), .ctl1_q(ctl1_q),
    .ctl2_q(ctl2_q), .arm_q(arm_q), .guard_q(guard_q));

  // reference model: register contents by offset
  logic [7:0] m [0:4];

  function automatic logic [7:0] m_guard();
    return m[3][7] ? m[4] : 8'h00;
  endfunction

  always @(posedge clk) begin
    logic was_armed;
    was_armed = m[3][7];
    if (rst) begin
      for (int i = 0; i < 5; i++) m[i] = 8'h00;
    end else begin
      if (!was_armed) m[4] = 8'h00;
      if (bus_grant && port_sel && wr_en) begin
        if (addr < 3'd4) m[addr] = wdata;
        else if (addr == 3'd4 && was_armed) m[4] = wdata;
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read();
    if (!(bus_grant && port_sel && rd_en)) return 8'h00;
    case (addr)
      3'd0, 3'd1, 3'd2: return m[addr];
      3'd3: return ext_status;
      3'd4: return m_guard();
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      check("R1", ctl0_q, m[0]);
      check("R1", ctl1_q, m[1]);
      check("R1", ctl2_q, m[2]);
      check("R5", arm_q, m[3]);
      check("R6", guard_q, m_guard());
      check("R4", rdata, m_read());
    end
  end

  task automatic drive(bit g, bit s, bit w, bit r, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_grant = g; port_sel = s; wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask
  task automatic wr(logic [2:0] a, logic [7:0] d); drive(1, 1, 1, 0, a, d); endtask
  task automatic rd(logic [2:0] a); drive(1, 1, 0, 1, a, 8'h00); #1; endtask
  task automatic idle(); drive(0, 0, 0, 0, 3'd0, 8'h00); #1; endtask

  initial begin
    for (int i = 0; i < 5; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check("R2", ctl0_q | ctl1_q | ctl2_q | arm_q | guard_q, 8'h00);
    @(negedge clk); rst = 0;

    wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33); idle();
    rd(3'd0); check("R1", rdata, 8'h11);
    rd(3'd2); check("R1", rdata, 8'h33);

    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF); idle();
    for (int a = 5; a < 8; a++) begin rd(3'(a)); check("R9", rdata, 8'h00); end

    drive(0, 1, 1, 0, 3'd0, 8'h99); drive(1, 0, 1, 0, 3'd1, 8'h99);
    drive(1, 1, 0, 0, 3'd2, 8'h99); idle();
    check("R3", ctl0_q, 8'h11); check("R3", ctl1_q, 8'h22); check("R3", ctl2_q, 8'h33);

    drive(0, 1, 0, 1, 3'd0, 8'h00); #1; check("R4", rdata, 8'h00);

    wr(3'd4, 8'h5A); idle(); check("R6", guard_q, 8'h00);
    rd(3'd4); check("R6", rdata, 8'h00);

    ext_status = 8'h3C;
    wr(3'd3, 8'h95); wr(3'd4, 8'hA5); idle();
    check("R7", guard_q, 8'hA5); check("R5", arm_q, 8'h95);
    rd(3'd4); check("R7", rdata, 8'hA5);
    rd(3'd3); check("R5", rdata, 8'h3C);

    wr(3'd3, 8'h01); idle(); check("R8", guard_q, 8'h00);
    wr(3'd3, 8'h80); idle(); check("R8", guard_q, 8'h00);

    for (int k = 0; k < 400; k++) begin
      ext_status = 8'($urandom);
      drive(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 2 == 1,
            3'($urandom), 8'($urandom));
      if (k % 50 == 7) begin rst = 1; @(negedge clk); rst = 0; end
    end
    idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule